// File: doc/BRIEF.md
# Signed Array Multiplier

This block multiplies two WIDTH-bit two's-complement operands and returns their exact signed product on a 2*WIDTH-bit output. It has no clock and no state. The output follows the operands after the delay of the gate array, so a register stage belongs to the surrounding datapath.

Each pair of operand bits is ANDed to form a partial-product term, which gives WIDTH*WIDTH terms. A term that carries the sign bit of exactly one operand is inverted. A constant one enters the array at weight 2^WIDTH, and the top output bit is inverted. With these corrections the unsigned sum of the array equals the signed product modulo 2^(2*WIDTH), so no sign-magnitude conversion is needed. The reduction is WIDTH-1 rows of WIDTH adder cells each, which is WIDTH*WIDTH - WIDTH cells in total. The lowest cell of every row has no carry input and is a half adder. The other cells are full adders.

Top module: `sgn_array_mult`

## Requirements
- R1: For every pair of WIDTH-bit signed operands, `product` equals op_a × op_b as a signed 2*WIDTH-bit value (8 bits for the default WIDTH = 4).
- R2: A partial-product term built from exactly one operand sign bit (bit WIDTH-1) is inverted. The term built from both sign bits is not inverted. As a result, products with a negative operand are exact, for example -8 × 3 = 0xE8 and 7 × -8 = 0xC8.
- R3: The correction constant 1 added at bit WIDTH and the inversion of product bit 2*WIDTH-1 together make the result exact at the range limits: -8 × 7 = 0xC8 and -8 × -1 = 0x08.
- R4: 0xF (-1) times 0x7 (+7) gives 0xF9 (-7).
- R5: A zero on either operand gives a zero product.
- R6: The most negative operand multiplied by itself gives +2^(2*WIDTH-2), which is 0x40 for WIDTH = 4.
- R7: Multiplying by +1 returns the other operand sign-extended to 2*WIDTH bits.
- R8: When both operands are nonzero, product bit 2*WIDTH-1 equals the XOR of the two operand sign bits.
- R9: Swapping the operands leaves the product unchanged.
- R10: The block is purely combinational. A new operand pair shows on `product` within the same clock period, and no clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Multiplicand, two's complement |
| op_b | input | WIDTH | Multiplier, two's complement |
| product | output | 2*WIDTH | Signed product, two's complement |

## Verification
The assertions are evaluated whenever the operands change. They check that the product equals the signed product and that each adder row returns the true sum of its two inputs. They also check the zero-operand, unit-operand and sign-bit rules. The bench's scenarios are needed for the rest: operand symmetry, settling within one period with no clock dependence, and full coverage of every operand pair. Together with the named corner pairs, that coverage is what shows the inversion pattern and the correction constant are right.

// File: rtl/sgn_mul_pkg.sv
package sgn_mul_pkg;

    localparam int unsigned MIN_WIDTH = 2;

    // A term is complemented when exactly one of its two bits is a sign bit.
    function automatic bit term_is_flipped(input int row, input int col, input int width);
        return (row == width - 1) != (col == width - 1);
    endfunction

endpackage

// File: rtl/sgn_half_add.sv
module sgn_half_add (
    input  logic in_x,
    input  logic in_y,
    output logic sum,
    output logic carry
);
    assign sum   = in_x ^ in_y;
    assign carry = in_x & in_y;
endmodule

// File: rtl/sgn_full_add.sv
module sgn_full_add (
    input  logic in_x,
    input  logic in_y,
    input  logic in_c,
    output logic sum,
    output logic carry
);
    logic part_sum;
    logic part_c0;
    logic part_c1;

    sgn_half_add u_ha_lo (.in_x(in_x),     .in_y(in_y), .sum(part_sum), .carry(part_c0));
    sgn_half_add u_ha_hi (.in_x(part_sum), .in_y(in_c), .sum(sum),      .carry(part_c1));

    assign carry = part_c0 | part_c1;
endmodule

// File: rtl/sgn_pp_gen.sv
module sgn_pp_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]       op_a,
    input  logic [WIDTH-1:0]       op_b,
    output logic [WIDTH*WIDTH-1:0] terms
);
    // terms[r*WIDTH + c] has weight 2^(r+c) and comes from op_a[c] and op_b[r].
    for (genvar r = 0; r < WIDTH; r++) begin : g_row
        for (genvar c = 0; c < WIDTH; c++) begin : g_col
            if (sgn_mul_pkg::term_is_flipped(r, c, WIDTH)) begin : g_flip
                assign terms[r*WIDTH + c] = ~(op_a[c] & op_b[r]);
            end else begin : g_keep
                assign terms[r*WIDTH + c] = op_a[c] & op_b[r];
            end
        end
    end
endmodule

// File: rtl/sgn_row_adder.sv
module sgn_row_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] pp_in,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] chain;

    for (genvar j = 0; j < WIDTH; j++) begin : g_cell
        if (j == 0) begin : g_half
            sgn_half_add u_cell (
                .in_x(acc_in[0]), .in_y(pp_in[0]), .sum(sum[0]), .carry(chain[0])
            );
        end else begin : g_full
            sgn_full_add u_cell (
                .in_x(acc_in[j]), .in_y(pp_in[j]), .in_c(chain[j-1]),
                .sum(sum[j]), .carry(chain[j])
            );
        end
    end

    assign cout = chain[WIDTH-1];

    always_comb begin
        if (!$isunknown({acc_in, pp_in, sum, cout})) begin
            AST_ROW_SUM: assert ({cout, sum} == ({1'b0, acc_in} + {1'b0, pp_in})); // R1
        end
    end
endmodule

// File: rtl/sgn_array_mult.sv
module sgn_array_mult #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;

    logic [WIDTH*WIDTH-1:0] terms;
    logic [WIDTH-1:0]       row_sum  [WIDTH];
    logic                   row_cout [WIDTH];

    sgn_pp_gen #(.WIDTH(WIDTH)) u_pp (.op_a(op_a), .op_b(op_b), .terms(terms));

    // Row 0 is the first partial product by itself. Its carry slot holds the
    // correction constant, which enters the array at weight 2^WIDTH.
    assign row_sum[0]  = terms[WIDTH-1:0];
    assign row_cout[0] = 1'b1;

    for (genvar r = 1; r < WIDTH; r++) begin : g_rows
        sgn_row_adder #(.WIDTH(WIDTH)) u_row (
            .acc_in({row_cout[r-1], row_sum[r-1][WIDTH-1:1]}),
            .pp_in (terms[r*WIDTH +: WIDTH]),
            .sum   (row_sum[r]),
            .cout  (row_cout[r])
        );
    end

    for (genvar r = 0; r < WIDTH - 1; r++) begin : g_low
        assign product[r] = row_sum[r][0];
    end
    assign product[PW-2:WIDTH-1] = row_sum[WIDTH-1];
    assign product[PW-1]         = ~row_cout[WIDTH-1];

    // Checks at the ports.
    logic signed [PW-1:0] ref_prod;
    logic                 inputs_known;

    always_comb begin
        inputs_known = !$isunknown({op_a, op_b, product});
        ref_prod = $signed({{WIDTH{op_a[WIDTH-1]}}, op_a}) * $signed({{WIDTH{op_b[WIDTH-1]}}, op_b});
    end

    always_comb begin
        if (inputs_known) begin
            AST_EXACT_PRODUCT: assert (product == ref_prod); // R1
            if (op_a == '0 || op_b == '0) begin
                AST_ZERO_OPERAND: assert (product == '0); // R5
            end
            if (op_b == WIDTH'(1)) begin
                AST_UNIT_OPERAND: assert (product == {{WIDTH{op_a[WIDTH-1]}}, op_a}); // R7
            end
            if (op_a != '0 && op_b != '0) begin
                AST_SIGN_BIT: assert (product[PW-1] == (op_a[WIDTH-1] ^ op_b[WIDTH-1])); // R8
            end
        end
    end

    initial begin
        AST_WIDTH_OK: assert (WIDTH >= int'(sgn_mul_pkg::MIN_WIDTH)); // R1
    end
endmodule

// File: tb/tb_sgn_array_mult.sv
module tb_sgn_array_mult;
    localparam int WIDTH = 4;
    localparam int PW    = 2 * WIDTH;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic [PW-1:0]    product;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    sgn_array_mult #(.WIDTH(WIDTH)) dut (.op_a(op_a), .op_b(op_b), .product(product));

    always #5 clk = ~clk;

    // Expected product from repeated shifted addition over 2*WIDTH bits.
    function automatic logic [PW-1:0] expect_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        logic [PW-1:0] ea = {{WIDTH{a[WIDTH-1]}}, a};
        logic [PW-1:0] eb = {{WIDTH{b[WIDTH-1]}}, b};
        logic [PW-1:0] acc = '0;
        for (int k = 0; k < PW; k++) begin
            if (eb[k]) acc = acc + (ea << k);
        end
        return acc;
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h got=%h expected=%h", tag, op_a, op_b, got, exp);
        end
    endtask

    task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        #2;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [PW-1:0] first;
        logic [WIDTH-1:0] ra;
        logic [WIDTH-1:0] rb;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #2;
        check("R5 reset state", product, '0);
        rst = 1'b0;

        apply(4'hF, 4'h7); check("R4 minus1 times 7", product, 8'hF9);
        apply(4'h8, 4'h8); check("R6 min squared", product, 8'h40);
        apply(4'h8, 4'h3); check("R2 min times 3", product, 8'hE8);
        apply(4'h7, 4'h8); check("R2 7 times min", product, 8'hC8);
        apply(4'h8, 4'h7); check("R3 min times max", product, 8'hC8);
        apply(4'h8, 4'hF); check("R3 min times minus1", product, 8'h08);
        apply(4'h0, 4'h9); check("R5 zero a", product, 8'h00);
        apply(4'hA, 4'h0); check("R5 zero b", product, 8'h00);
        apply(4'h9, 4'h1); check("R7 times one", product, 8'hF9);
        apply(4'h7, 4'h7); check("R1 max squared", product, 8'h31);

        // R10: the product settles within the half period after the change, before any rising edge.
        @(posedge clk); #1;
        op_a = 4'hB; op_b = 4'h5;
        #2;
        check("R10 no clock needed", product, expect_mul(4'hB, 4'h5));

        // Exhaustive sweep over every operand pair.
        for (int a = 0; a < (1 << WIDTH); a++) begin
            for (int b = 0; b < (1 << WIDTH); b++) begin
                apply(WIDTH'(a), WIDTH'(b));
                check("R1 exhaustive", product, expect_mul(WIDTH'(a), WIDTH'(b)));
                if (a != 0 && b != 0) begin
                    checks++;
                    if (product[PW-1] !== (op_a[WIDTH-1] ^ op_b[WIDTH-1])) begin
                        failures++;
                        $display("FAIL R8 sign a=%h b=%h got=%b expected=%b",
                                 op_a, op_b, product[PW-1], op_a[WIDTH-1] ^ op_b[WIDTH-1]);
                    end
                end
            end
        end

        // Random pairs with a fixed seed. Each pair is checked in both orders.
        for (int n = 0; n < 200; n++) begin
            ra = WIDTH'($urandom);
            rb = WIDTH'($urandom);
            apply(ra, rb);
            first = product;
            check("R1 random", product, expect_mul(ra, rb));
            apply(rb, ra);
            check("R9 swapped", product, first);
        end

        summary();
    end
endmodule